// File: doc/BRIEF.md
# Dual-Core Interrupt Router

This block collects level-sensitive interrupt sources and steers each one to two processors: a main CPU and a coprocessor. Each processor has its own enable mask and its own per-source steering bit. The steering bit sends a source to either the normal interrupt line (IRQ) or the fast interrupt line (FIQ). Software can also hold any source active through a forced register. Acknowledgement happens at each source, so the router stores no interrupt state beyond the forced bits.

Sources are spread over two 32-bit words. The low word holds sources 0 to 29 (`src[29:0]`). The high word holds the upper group, which starts at source 30 (`src[NSRC-1:30]`). Bit 30 of every low-word status read summarises the high word.

The fixed source positions are:

| Source | Word and bit | `src` index |
|---|---|---|
| timer1 | low bit 0 | 0 |
| timer2 | low bit 1 | 1 |
| mailbox | low bit 4 | 4 |
| GPIO | high bit 0 | 30 |
| serial0 | high bit 4 | 34 |
| serial1 | high bit 5 | 35 |

Registers sit on a simple bus. `addr[4:1]` selects a register group and `addr[0]` selects the low word (0) or the high word (1). Writes take effect at the rising clock edge when `we` is 1. `rdata` is combinational from `addr`.

Top module: `dual_irq_router`

## Requirements
- R1: After reset, all masks, steering bits and forced bits read 0, and all four interrupt outputs are 0.
- R2: The raw pending value is `src | forced`. It reads at group 0, which is address 0 (low word) and address 1 (high word).
- R3: A write to forced-set (group 2, addresses 4 and 5) ORs the 1 bits into the forced register. A write to forced-clear (group 3, addresses 6 and 7) clears the bits written as 1. Bits written as 0 leave their bit unchanged. The forced register reads at group 1 (addresses 2 and 3). Set and clear registers read 0.
- R4: Each processor has its own mask. The CPU mask reads at group 4, its set register is group 5 and its clear register is group 6. The coprocessor mask reads at group 8, its set register is group 9 and its clear register is group 10. Set and clear follow the same rules as R3. A write to one processor's registers leaves the other processor's mask unchanged.
- R5: Steering registers are read/write: group 7 for the CPU and group 11 for the coprocessor. A steering bit of 0 routes the source to IRQ, and a 1 routes it to FIQ.
- R6: Each IRQ or FIQ output is 1 when at least one source meets all three conditions: raw bit 1, that processor's mask bit 1, and a matching steering bit. The output is registered, so it changes one clock edge after its inputs change.
- R7: In every low-word read, bit 30 is the OR of the corresponding high word and bit 31 is 0. Bits 31:30 of a low-word write are ignored.
- R8: Four read-only status registers show, per source, what feeds each output. Group 12 is CPU IRQ, group 13 is coprocessor IRQ, group 14 is CPU FIQ and group 15 is coprocessor FIQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NSRC (62) | Level-sensitive interrupt sources |
| we | input | 1 | Register write enable |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| cpu_irq | output | 1 | CPU normal interrupt |
| cpu_fiq | output | 1 | CPU fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |

## Verification
The routing function is tried with three kinds of stimulus. An external source alone checks that the OR with the forced bits feeds routing. A forced bit with no external line checks the same OR from the other side. A mix of low-group and high-group sources checks that the high-word summary in bit 30 is formed. Running the same source with its steering bit at 0 and then at 1 tells IRQ steering apart from FIQ steering. Setting a mask on one processor only tells a shared mask apart from separate masks. Sampling an output just before and just after the capturing edge separates a registered output from a combinational one.

// File: rtl/dual_irq_router.sv
module dual_irq_router #(
  parameter int HI_N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [30+HI_N-1:0]   src,
  input  logic                 we,
  input  logic [4:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 cpu_irq,
  output logic                 cpu_fiq,
  output logic                 cop_irq,
  output logic                 cop_fiq
);
  localparam int LO_N = 30;
  localparam int NSRC = LO_N + HI_N;

  logic [NSRC-1:0] forced, mask_c, mask_p, prio_c, prio_p;
  logic [NSRC-1:0] raw, pend_c, pend_p, wvec, wsel, rvec;
  logic [3:0]      grp;

  assign grp    = addr[4:1];
  assign raw    = src | forced;
  assign pend_c = raw & mask_c;
  assign pend_p = raw & mask_p;
  assign wvec   = addr[0] ? {wdata[HI_N-1:0], {LO_N{1'b0}}} : {{HI_N{1'b0}}, wdata[LO_N-1:0]};
  assign wsel   = addr[0] ? {{HI_N{1'b1}}, {LO_N{1'b0}}} : {{HI_N{1'b0}}, {LO_N{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forced <= '0;
      mask_c <= '0;
      mask_p <= '0;
      prio_c <= '0;
      prio_p <= '0;
    end else if (we) begin
      case (grp)
        4'd2:  forced <= forced | wvec;
        4'd3:  forced <= forced & ~wvec;
        4'd5:  mask_c <= mask_c | wvec;
        4'd6:  mask_c <= mask_c & ~wvec;
        4'd7:  prio_c <= (prio_c & ~wsel) | wvec;
        4'd9:  mask_p <= mask_p | wvec;
        4'd10: mask_p <= mask_p & ~wvec;
        4'd11: prio_p <= (prio_p & ~wsel) | wvec;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      cpu_fiq <= 1'b0;
      cop_irq <= 1'b0;
      cop_fiq <= 1'b0;
    end else begin
      cpu_irq <= |(pend_c & ~prio_c);
      cpu_fiq <= |(pend_c & prio_c);
      cop_irq <= |(pend_p & ~prio_p);
      cop_fiq <= |(pend_p & prio_p);
    end
  end

  always_comb begin
    case (grp)
      4'd0:    rvec = raw;
      4'd1:    rvec = forced;
      4'd4:    rvec = mask_c;
      4'd7:    rvec = prio_c;
      4'd8:    rvec = mask_p;
      4'd11:   rvec = prio_p;
      4'd12:   rvec = pend_c & ~prio_c;
      4'd13:   rvec = pend_p & ~prio_p;
      4'd14:   rvec = pend_c & prio_c;
      4'd15:   rvec = pend_p & prio_p;
      default: rvec = '0;
    endcase
  end

  assign rdata = addr[0] ? 32'(rvec[NSRC-1:LO_N])
                         : {1'b0, |rvec[NSRC-1:LO_N], rvec[LO_N-1:0]};

  a_r3_force_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we && grp == 4'd2) |=> ((forced & $past(wvec)) == $past(wvec)));
  a_r3_force_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && grp == 4'd3) |=> ((forced & $past(wvec)) == '0));
  a_r4_cpu_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we && grp == 4'd5) |=> ((mask_c & $past(wvec)) == $past(wvec) && $stable(mask_p)));
  a_r4_cop_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && grp == 4'd10) |=> ((mask_p & $past(wvec)) == '0 && $stable(mask_c)));
  a_r5_no_fiq_unsteered: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_c == '0) |=> !cpu_fiq);
  a_r6_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_p == '0) |=> (!cop_irq && !cop_fiq));
endmodule

// File: tb/dual_irq_router_tb.sv
module dual_irq_router_tb;
  localparam int NSRC = 62;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic cpu_irq, cpu_fiq, cop_irq, cop_fiq;
  int checks = 0, failures = 0;

  dual_irq_router u_dut (.clk(clk), .rst_n(rst_n), .src(src), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
    .cop_irq(cop_irq), .cop_fiq(cop_fiq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, cop_fiq, cop_irq, cpu_fiq, cpu_irq};
  endfunction

  task automatic t_reset();
    rdchk("R1 cpu mask", 5'd8, 0);
    rdchk("R1 cop mask hi", 5'd17, 0);
    rdchk("R1 cpu steer", 5'd14, 0);
    rdchk("R1 forced", 5'd2, 0);
    chk("R1 outputs", outs(), 0);
  endtask

  task automatic t_raw();
    @(negedge clk); src = '0; src[0] = 1'b1; src[34] = 1'b1;
    rdchk("R2 R7 raw lo summary", 5'd0, 32'h4000_0001);
    rdchk("R2 raw hi", 5'd1, 32'h10);
    @(negedge clk); src = '0;
    rdchk("R7 raw lo no summary", 5'd0, 32'h0);
  endtask

  task automatic t_force();
    wr(5'd4, 32'h5);
    rdchk("R3 forced set", 5'd2, 32'h5);
    wr(5'd4, 32'h0);
    rdchk("R3 zero write no change", 5'd2, 32'h5);
    wr(5'd6, 32'h1);
    rdchk("R3 forced clear", 5'd2, 32'h4);
    wr(5'd4, 32'hC000_0000);
    rdchk("R7 low bits 31:30 ignored", 5'd2, 32'h4);
    rdchk("R2 raw includes forced", 5'd0, 32'h4);
    rdchk("R3 set reg reads 0", 5'd4, 32'h0);
    wr(5'd6, 32'hFFFF_FFFF);
    rdchk("R3 clear all", 5'd2, 32'h0);
  endtask

  task automatic t_mask();
    wr(5'd10, 32'h13);
    rdchk("R4 cpu mask set", 5'd8, 32'h13);
    rdchk("R4 cop mask untouched", 5'd16, 32'h0);
    wr(5'd12, 32'h2);
    rdchk("R4 cpu mask clear", 5'd8, 32'h11);
    wr(5'd19, 32'h21);
    rdchk("R4 cop mask hi set", 5'd17, 32'h21);
    rdchk("R4 cpu mask hi untouched", 5'd9, 32'h0);
  endtask

  task automatic t_route_cpu();
    wr(5'd14, 32'h10);
    rdchk("R5 steer readback", 5'd14, 32'h10);
    @(negedge clk); src = '0; src[0] = 1'b1;
    #1 chk("R6 not yet", outs(), 0);
    @(negedge clk);
    chk("R5 R6 timer1 to cpu irq", outs(), 32'h1);
    rdchk("R8 cpu irq status", 5'd24, 32'h1);
    rdchk("R8 cpu fiq status empty", 5'd28, 32'h0);
    @(negedge clk); src = '0; src[4] = 1'b1;
    @(negedge clk);
    chk("R5 mailbox to cpu fiq", outs(), 32'h2);
    rdchk("R8 cpu fiq status", 5'd28, 32'h10);
    wr(5'd12, 32'h10);
    chk("R6 still high one edge", outs(), 32'h2);
    @(negedge clk);
    chk("R6 low after mask clear", outs(), 32'h0);
    @(negedge clk); src = '0;
  endtask

  task automatic t_route_cop();
    wr(5'd23, 32'h20);
    @(negedge clk); src = '0; src[30] = 1'b1;
    @(negedge clk);
    chk("R6 gpio to cop irq", outs(), 32'h4);
    @(negedge clk); src = '0; src[35] = 1'b1;
    @(negedge clk);
    chk("R5 serial1 to cop fiq", outs(), 32'h8);
    rdchk("R7 R8 cop fiq lo summary", 5'd30, 32'h4000_0000);
    rdchk("R8 cop fiq hi", 5'd31, 32'h20);
    rdchk("R8 cop irq hi empty", 5'd27, 32'h0);
    @(negedge clk); src = '0;
  endtask

  task automatic t_force_route();
    wr(5'd10, 32'h2);
    wr(5'd4, 32'h2);
    @(negedge clk);
    chk("R2 forced timer2 drives cpu irq", outs(), 32'h1);
    wr(5'd6, 32'h2);
    @(negedge clk);
    chk("R3 cleared force drops irq", outs(), 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw();
        t_force();
        t_mask();
        t_route_cpu();
        t_route_cop();
        t_force_route();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule